// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator with Per-Line Bypass

This block sits between a set of peripheral interrupt lines and a parent interrupt controller. It takes 32 level-sensitive request lines, brings them into its clock domain through a two-stage synchroniser, and folds them onto a small number of aggregated outputs. Each aggregated output carries the OR of the lines assigned to it that are currently high and enabled. The assignment is set per output by a mask fixed at elaboration. Positions that no mask names are dead: they never reach any output.

A few lines, chosen by an elaboration mask, have a bypass mux. A run-time select input picks, per such line, between two routes. In the first, the line leaves on its own dedicated output and the enable register has no effect on it. In the second, the line is handled inside the block like any other mapped line and is folded onto one chosen aggregated output. A two-word register interface exposes the enable word and a read-only status word. A suspend input overlays wake-enable and bypass bits onto the enable word on entry and puts the earlier value back on exit.

Top module: `irq_cascade_agg`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every aggregated output and every dedicated output is 0, and the enable word reads 0.
- R2: A write at byte offset 0x0 loads the enable word, and a read at 0x0 returns it in the same cycle that the address is presented.
- R3: A read at offset 0x4 returns the status word. Status bit i is 1 only when the synchronised line i is high, enable bit i is 1, and line i is handled internally (it is mapped, or it is a bypass-capable line whose select bit is 0). Writes to 0x4 change neither the status word nor the enable word.
- R4: A read at any offset other than 0x0 and 0x4 returns 0.
- R5: Aggregated output k (bit k of the output vector) is the OR of the status bits in its map, registered. With the default maps, bit 0 collects lines 3, 4, 5, 7, 9, 10 and 11, and bit 1 collects lines 6 and 8. A line change reaches the output on the third rising edge after it is applied.
- R6: Lines 12 to 31, which no map names under the defaults, never raise an aggregated output, a dedicated output or a status bit, whatever the enable word holds.
- R7: With the default bypass mask, lines 0, 1 and 2 can bypass the block. When select bit i is 1, dedicated output bit i follows line i with the same latency whatever the enable word holds, and line i appears neither in the status word nor on any aggregated output.
- R8: When select bit i of a bypass-capable line is 0, dedicated output bit i stays 0 and the line is folded onto aggregated output 0, gated by enable bit i.
- R9: On the cycle after suspend rises, the enable word holds its previous value ORed with the wake-enable input and the active bypass selects. On the cycle after suspend falls, it holds the value it had just before suspend rose. Writes made during suspend are lost.
- R10: When suspend rises in the same cycle as a write to the enable word, the suspend overlay wins and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | 32 | Level-sensitive request lines, asynchronous |
| fwd_sel_i | input | 32 | Per-line bypass select. It only has an effect on bypass-capable lines |
| wake_en_i | input | 32 | Wake-enable bits ORed into the enable word on suspend entry |
| suspend_i | input | 1 | Suspend request, synchronous level |
| reg_addr_i | input | 4 | Register byte offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| agg_irq_o | output | 2 | Aggregated outputs toward the parent |
| fwd_irq_o | output | 32 | Dedicated bypass outputs. Only bypass-capable bits are ever 1 |

## Verification
The hardest case to reach is a bypass-capable line whose select flips while the line is held high. The line must then leave one route and enter the other without showing on both at once. It must also not show on the wrong route for the two cycles that the synchroniser holds it. The stimulus walks each of lines 0 to 2 through both select settings with the line held high and every enable bit set. A reference model compares both output routes and the read data on every clock, so a cycle in which the line appears on both routes is caught. The suspend overlay is reached in two ways: by writes made while suspended, and by a write that lands in the same cycle as suspend entry.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

   typedef enum logic [1:0] {
      RSEL_ENABLE,
      RSEL_STATUS,
      RSEL_NONE
   } reg_sel_e;

   // Decode a byte offset against the two defined offsets.
   function automatic reg_sel_e decode_sel(input int unsigned addr,
                                           input int unsigned en_ofs,
                                           input int unsigned st_ofs);
      if (addr == en_ofs)      return RSEL_ENABLE;
      else if (addr == st_ofs) return RSEL_STATUS;
      else                     return RSEL_NONE;
   endfunction

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   logic [WIDTH-1:0] stage_q [STAGES];

   initial begin
      assert (STAGES >= 2) else $error("irq_line_sync: need at least two stages");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= async_i;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic             suspend_i,
   input  logic [WIDTH-1:0] wake_en_i,
   input  logic [WIDTH-1:0] fwd_eff_i,
   output logic [WIDTH-1:0] enable_o,
   output logic [WIDTH-1:0] saved_o
);

   logic [WIDTH-1:0] enable_q;
   logic [WIDTH-1:0] saved_q;
   logic             susp_q;
   logic             enter_w;
   logic             leave_w;

   assign enter_w = suspend_i & ~susp_q;
   assign leave_w = ~suspend_i & susp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
         saved_q  <= '0;
         susp_q   <= 1'b0;
      end else begin
         susp_q <= suspend_i;
         if (enter_w) begin
            saved_q  <= enable_q;
            enable_q <= enable_q | fwd_eff_i | wake_en_i;
         end else if (leave_w) begin
            enable_q <= saved_q;
         end else if (wr_i) begin
            enable_q <= wdata_i;
         end
      end
   end

   assign enable_o = enable_q;
   assign saved_o  = saved_q;

   // R10: a write that coincides with suspend entry must not land
   a_r10_enter_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
      (enter_w && wr_i) |=> (enable_q == ($past(enable_q) | $past(fwd_eff_i) | $past(wake_en_i))));

endmodule

// File: rtl/irq_route.sv
module irq_route #(
   parameter int unsigned           WIDTH    = 32,
   parameter int unsigned           NUM_AGG  = 2,
   parameter logic [NUM_AGG*WIDTH-1:0] AGG_MAP = {32'h0000_0140, 32'h0000_0EB8},
   parameter logic [WIDTH-1:0]      MUX_MASK = 32'h0000_0007,
   parameter int unsigned           FOLD_IDX = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [WIDTH-1:0]   lines_i,
   input  logic [WIDTH-1:0]   enable_i,
   input  logic [WIDTH-1:0]   fwd_eff_i,
   output logic [WIDTH-1:0]   status_o,
   output logic [NUM_AGG-1:0] agg_o,
   output logic [WIDTH-1:0]   dir_o
);

   function automatic logic [WIDTH-1:0] union_of_maps();
      logic [WIDTH-1:0] acc = '0;
      for (int k = 0; k < NUM_AGG; k++) acc |= AGG_MAP[k*WIDTH +: WIDTH];
      return acc;
   endfunction

   localparam logic [WIDTH-1:0] MAPPED_ALL = union_of_maps();
   localparam logic [WIDTH-1:0] REACHABLE  = MAPPED_ALL | MUX_MASK;

   logic [WIDTH-1:0] internal_w;

   // Lines handled inside: mapped lines plus bypass lines that stay in.
   assign internal_w = REACHABLE & ~fwd_eff_i;
   assign status_o   = lines_i & enable_i & internal_w;

   for (genvar k = 0; k < NUM_AGG; k++) begin : g_agg
      localparam logic [WIDTH-1:0] MAP_K   = AGG_MAP[k*WIDTH +: WIDTH];
      localparam logic [WIDTH-1:0] FOLD_K  = (k == FOLD_IDX) ? MUX_MASK : '0;
      localparam logic [WIDTH-1:0] GROUP_K = MAP_K | FOLD_K;
      logic agg_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) agg_q <= 1'b0;
         else        agg_q <= |(status_o & GROUP_K);
      end
      assign agg_o[k] = agg_q;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_dir
      if (MUX_MASK[i]) begin : g_mux
         logic dir_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dir_q <= 1'b0;
            else        dir_q <= lines_i[i] & fwd_eff_i[i];
         end
         assign dir_o[i] = dir_q;
      end else begin : g_plain
         assign dir_o[i] = 1'b0;
      end
   end

endmodule

// File: rtl/irq_cascade_agg.sv
module irq_cascade_agg #(
   parameter int unsigned              NUM_LINES = 32,
   parameter int unsigned              NUM_AGG   = 2,
   parameter logic [NUM_AGG*NUM_LINES-1:0] AGG_MAP = {32'h0000_0140, 32'h0000_0EB8},
   parameter logic [NUM_LINES-1:0]     MUX_MASK  = 32'h0000_0007,
   parameter int unsigned              FOLD_IDX  = 0,
   parameter int unsigned              ADDR_W    = 4,
   parameter int unsigned              EN_OFS    = 0,
   parameter int unsigned              STAT_OFS  = 4,
   parameter int unsigned              SYNC_STG  = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines_i,
   input  logic [NUM_LINES-1:0] fwd_sel_i,
   input  logic [NUM_LINES-1:0] wake_en_i,
   input  logic                 suspend_i,
   input  logic [ADDR_W-1:0]    reg_addr_i,
   input  logic                 reg_we_i,
   input  logic [NUM_LINES-1:0] reg_wdata_i,
   output logic [NUM_LINES-1:0] reg_rdata_o,
   output logic [NUM_AGG-1:0]   agg_irq_o,
   output logic [NUM_LINES-1:0] fwd_irq_o
);
   import irq_cascade_pkg::*;

   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   function automatic logic [NUM_LINES-1:0] map_union();
      logic [NUM_LINES-1:0] acc = '0;
      for (int k = 0; k < NUM_AGG; k++) acc |= AGG_MAP[k*NUM_LINES +: NUM_LINES];
      return acc;
   endfunction

   localparam logic [NUM_LINES-1:0] MAPPED_ALL = map_union();

   initial begin
      assert (NUM_LINES >= 1 && NUM_LINES <= 32) else $error("line count out of range");
      assert (NUM_AGG >= 1) else $error("need at least one aggregated output");
      assert (FOLD_IDX < NUM_AGG) else $error("fold target out of range");
      assert ((MAPPED_ALL & MUX_MASK) == '0) else $error("bypass lines must not be mapped");
      assert (EN_OFS != STAT_OFS) else $error("register offsets collide");
      assert (EN_OFS < ADDR_SPAN && STAT_OFS < ADDR_SPAN) else $error("offset beyond address space");
   end

   logic [NUM_LINES-1:0] lines_s;
   logic [NUM_LINES-1:0] fwd_eff;
   logic [NUM_LINES-1:0] enable_w;
   logic [NUM_LINES-1:0] saved_w;
   logic [NUM_LINES-1:0] status_w;
   reg_sel_e             sel_w;

   assign fwd_eff = fwd_sel_i & MUX_MASK;
   assign sel_w   = decode_sel(32'(reg_addr_i), EN_OFS, STAT_OFS);

   irq_line_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STG)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (irq_lines_i),
      .sync_o  (lines_s)
   );

   irq_enable_ctl #(.WIDTH(NUM_LINES)) u_enable (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (reg_we_i && (sel_w == RSEL_ENABLE)),
      .wdata_i   (reg_wdata_i),
      .suspend_i (suspend_i),
      .wake_en_i (wake_en_i),
      .fwd_eff_i (fwd_eff),
      .enable_o  (enable_w),
      .saved_o   (saved_w)
   );

   irq_route #(
      .WIDTH    (NUM_LINES),
      .NUM_AGG  (NUM_AGG),
      .AGG_MAP  (AGG_MAP),
      .MUX_MASK (MUX_MASK),
      .FOLD_IDX (FOLD_IDX)
   ) u_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .lines_i   (lines_s),
      .enable_i  (enable_w),
      .fwd_eff_i (fwd_eff),
      .status_o  (status_w),
      .agg_o     (agg_irq_o),
      .dir_o     (fwd_irq_o)
   );

   always_comb begin
      unique case (sel_w)
         RSEL_ENABLE: reg_rdata_o = enable_w;
         RSEL_STATUS: reg_rdata_o = status_w;
         default:     reg_rdata_o = '0;
      endcase
   end

   // R1: outputs are quiet on the cycle after any cycle spent in reset
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (agg_irq_o == '0 && fwd_irq_o == '0));

   // R5: no status bit set means no aggregated output on the next cycle
   a_r5_agg_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
      (status_w == '0) |=> (agg_irq_o == '0));

   // R7: with a steady select, a line is never on both routes at once
   a_r7_route_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(fwd_sel_i) |-> ((fwd_irq_o & status_w) == '0));

   // R9: suspend entry sets every wake and bypass bit in the enable word
   a_r9_suspend_overlay: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(suspend_i) && $past(rst_n)) |=>
         ((enable_w & $past(fwd_eff | wake_en_i)) == $past(fwd_eff | wake_en_i)));

   // R9: suspend exit restores the saved word
   a_r9_resume_restore: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(suspend_i) && $past(rst_n)) |=> (enable_w == $past(saved_w)));

endmodule

// File: tb/irq_cascade_agg_bench.sv
module irq_cascade_agg_bench;

   localparam logic [31:0] MAP_A = 32'h0000_0EB8;
   localparam logic [31:0] MAP_B = 32'h0000_0140;
   localparam logic [31:0] BYP   = 32'h0000_0007;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lines = '0;
   logic [31:0] fsel = '0;
   logic [31:0] wake = '0;
   logic        susp = 1'b0;
   logic [3:0]  addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [1:0]  agg;
   logic [31:0] dir;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_cascade_agg u_irq_cascade_agg (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_lines_i (lines),
      .fwd_sel_i   (fsel),
      .wake_en_i   (wake),
      .suspend_i   (susp),
      .reg_addr_i  (addr),
      .reg_we_i    (we),
      .reg_wdata_i (wdata),
      .reg_rdata_o (rdata),
      .agg_irq_o   (agg),
      .fwd_irq_o   (dir)
   );

   // Behavioural reference: pipeline of line samples plus the enable word
   logic [31:0] m_p1, m_p2, m_en, m_saved, m_dir;
   logic [1:0]  m_agg;
   logic        m_susp;

   function automatic logic [31:0] m_status(input logic [31:0] p2, en, sel);
      logic [31:0] fe = sel & BYP;
      return p2 & en & ((MAP_A | MAP_B | BYP) & ~fe);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_p1 = '0; m_p2 = '0; m_en = '0; m_saved = '0;
         m_dir = '0; m_agg = '0; m_susp = 1'b0;
      end else begin
         logic [31:0] st, fe, n_en, n_saved;
         fe = fsel & BYP;
         st = m_status(m_p2, m_en, fsel);
         n_en = m_en; n_saved = m_saved;
         if (susp && !m_susp) begin
            n_saved = m_en; n_en = m_en | fe | wake;
         end else if (!susp && m_susp) begin
            n_en = m_saved;
         end else if (we && addr == 4'h0) begin
            n_en = wdata;
         end
         m_agg[0] = |(st & (MAP_A | BYP));
         m_agg[1] = |(st & MAP_B);
         m_dir = m_p2 & fe;
         m_en = n_en; m_saved = n_saved; m_susp = susp;
         m_p2 = m_p1; m_p1 = lines;
      end
   end

   // Cycle-level comparison (R5 latency, R7 routing, R2/R3/R4 read data)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [31:0] exp_rd;
         exp_rd = (addr == 4'h0) ? m_en :
                  (addr == 4'h4) ? m_status(m_p2, m_en, fsel) : 32'h0;
         checks++;
         if (agg !== m_agg) begin
            failures++;
            $display("FAIL R5 cycle agg act=%h exp=%h", agg, m_agg);
         end
         checks++;
         if (dir !== m_dir) begin
            failures++;
            $display("FAIL R7 cycle dir act=%h exp=%h", dir, m_dir);
         end
         checks++;
         if (rdata !== exp_rd) begin
            failures++;
            $display("FAIL R3 cycle rdata addr=%h act=%h exp=%h", addr, rdata, exp_rd);
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk); #1;
      we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk); #1;
      addr = a;
      #1 d = rdata;
   endtask

   task automatic set_lines(input logic [31:0] v);
      @(negedge clk); #1;
      lines = v;
      settle(4);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      settle(3);
      @(negedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 agg after reset", {30'b0, agg}, 32'h0);
      chk("R1 dir after reset", dir, 32'h0);
      rd(4'h0, v); chk("R1 enable after reset", v, 32'h0);

      // R2: enable word read/write
      wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, v); chk("R2 enable all", v, 32'hFFFF_FFFF);
      wr(4'h0, 32'h5A5A_00F0); rd(4'h0, v); chk("R2 enable pattern", v, 32'h5A5A_00F0);
      wr(4'h0, 32'hFFFF_FFFF);

      // R5: grouping onto outputs
      set_lines(32'h0000_0008);
      chk("R5 line3 agg", {30'b0, agg}, 32'h1);
      rd(4'h4, v); chk("R3 line3 status", v, 32'h0000_0008);
      set_lines(32'h0000_0040);
      chk("R5 line6 agg", {30'b0, agg}, 32'h2);
      set_lines(32'h0000_0EB8 | 32'h0000_0140);
      chk("R5 both groups", {30'b0, agg}, 32'h3);

      // R3: status write ignored
      wr(4'h4, 32'h0000_0000);
      rd(4'h0, v); chk("R3 enable after status write", v, 32'hFFFF_FFFF);
      rd(4'h4, v); chk("R3 status after status write", v, 32'h0000_0FF8);
      wr(4'h0, 32'h0000_0100);
      rd(4'h4, v); chk("R3 status gated by enable", v, 32'h0000_0100);
      settle(2);
      chk("R5 agg gated by enable", {30'b0, agg}, 32'h2);
      wr(4'h0, 32'hFFFF_FFFF);

      // R4: undefined offsets
      rd(4'h8, v); chk("R4 offset 0x8", v, 32'h0);
      rd(4'hC, v); chk("R4 offset 0xC", v, 32'h0);
      rd(4'h2, v); chk("R4 offset 0x2", v, 32'h0);

      // R6: dead positions
      set_lines(32'hFFFF_F000);
      chk("R6 agg dead lines", {30'b0, agg}, 32'h0);
      chk("R6 dir dead lines", dir, 32'h0);
      rd(4'h4, v); chk("R6 status dead lines", v, 32'h0);

      // R7 / R8: each bypass line in both settings, line held high
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); #1 fsel = '0;
         set_lines(32'h1 << i);
         chk("R8 folded agg", {30'b0, agg}, 32'h1);
         chk("R8 folded dir quiet", dir, 32'h0);
         @(negedge clk); #1 fsel = 32'h1 << i;
         settle(4);
         chk("R7 bypass dir", dir, 32'h1 << i);
         chk("R7 bypass agg quiet", {30'b0, agg}, 32'h0);
         rd(4'h4, v); chk("R7 bypass status quiet", v, 32'h0);
         @(negedge clk); #1 fsel = '0;
         settle(4);
         chk("R8 back to fold", {30'b0, agg}, 32'h1);
      end
      // R7: bypass ignores enable; R8: fold respects enable
      wr(4'h0, 32'h0);
      @(negedge clk); #1 fsel = 32'h0000_0002;
      set_lines(32'h0000_0002);
      chk("R7 bypass with enable clear", dir, 32'h2);
      @(negedge clk); #1 fsel = 32'h0;
      settle(4);
      chk("R8 fold needs enable", {30'b0, agg}, 32'h0);
      // a select bit on a non-bypass line has no effect
      wr(4'h0, 32'hFFFF_FFFF);
      @(negedge clk); #1 fsel = 32'h0000_0010;
      set_lines(32'h0000_0010);
      chk("R7 select ignored off bypass lines", dir, 32'h0);
      chk("R5 select ignored agg", {30'b0, agg}, 32'h1);
      @(negedge clk); #1 fsel = 32'h0;

      // R9: suspend overlay and restore
      set_lines(32'h0);
      wr(4'h0, 32'h0000_0010);
      @(negedge clk); #1 wake = 32'h0000_0100; fsel = 32'h0000_0005; susp = 1'b1;
      settle(1);
      rd(4'h0, v); chk("R9 suspend overlay", v, 32'h0000_0115);
      wr(4'h0, 32'h0000_0000);
      @(negedge clk); #1 susp = 1'b0;
      settle(1);
      rd(4'h0, v); chk("R9 resume restore", v, 32'h0000_0010);

      // R10: write in the suspend entry cycle is discarded
      @(negedge clk); #1
      susp = 1'b1; we = 1'b1; addr = 4'h0; wdata = 32'hFFFF_0000;
      @(negedge clk); #1 we = 1'b0;
      rd(4'h0, v); chk("R10 entry beats write", v, 32'h0000_0115);
      @(negedge clk); #1 susp = 1'b0;
      settle(1);
      rd(4'h0, v); chk("R10 restore after collision", v, 32'h0000_0010);

      settle(3);
      finish_run();
   end

endmodule